// File: doc/BRIEF.md
# I2C Byte-Level Master With Access-Triggered Transfers

This block is the bus side of an I2C master that software drives through three control bits, one data port and two status flags. No command register exists. A transfer starts as a side effect of touching the data port. In transmit mode, writing a byte shifts it onto the bus. In receive mode, reading the data port fetches the next byte. An access that does not match the direction bit starts nothing.

Setting the master-select bit claims the bus with a START condition. The first byte written after that goes out as the address byte: the 7-bit target in bits 7:1 and the read/write flag in bit 0. Clearing master-select releases the bus with a STOP condition.

Both bus lines are open-drain. The block only ever pulls a line low or lets it go. The line level seen on the bus is the wired-AND of every driver together with the pull-ups. A quarter-period prescaler sets the SCL rate.

Top module: `i2cm_reg_master`

## Requirements
- R1: After reset, the received-data port reads 0x00, the transfer-complete flag is 0, and neither line is pulled low.
- R2: When master-select goes from 0 to 1, SDA falls while SCL is high (START), and then SCL is held low until the next byte.
- R3: A data write with master-select = 1 and direction = transmit (ctrl_tx = 1) sends the byte MSB first as eight SCL pulses, then a ninth pulse with SDA released. SDA changes only while SCL is low.
- R4: The first byte written after a START is the address phase: a target whose 7-bit address equals bits 7:1 sees that address, with bit 0 as the read/write flag (1 = read).
- R5: After the ninth SCL pulse, xfer_done is set to 1. ack_seen is set to 1 if SDA was low during the ninth pulse (ACK) and to 0 if it was high (NACK). xfer_done clears when the next byte starts.
- R6: A data read with master-select = 1 and direction = receive (ctrl_tx = 0) clocks in eight bits MSB first. On the ninth pulse the master pulls SDA low (ACK) when ctrl_nack = 0 and leaves it released (NACK) when ctrl_nack = 1. Afterwards data_rdata returns the received byte.
- R7: A data read while direction = transmit starts no bus activity and leaves xfer_done unchanged.
- R8: A data write while direction = receive starts no bus activity. data_rdata keeps the last received byte, never the written value.
- R9: When master-select goes from 1 to 0, SDA rises while SCL is high (STOP), and then both lines are released.
- R10: During a byte, consecutive SCL rising edges are 4*(presc+1) clock cycles apart.
- R11: A data access made while a byte, START or STOP is in progress (busy = 1) is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| presc | input | PW | Quarter-bit period minus one, in clock cycles |
| ctrl_we | input | 1 | Write strobe for the three control bits |
| ctrl_master | input | 1 | Master-select bit |
| ctrl_tx | input | 1 | Direction bit: 1 transmit, 0 receive |
| ctrl_nack | input | 1 | 1: answer received bytes with NACK |
| data_we | input | 1 | Data port write strobe |
| data_wdata | input | DW | Byte to transmit |
| data_re | input | 1 | Data port read strobe |
| data_rdata | output | DW | Last received byte |
| xfer_done | output | 1 | Transfer-complete flag |
| ack_seen | output | 1 | 1 when the ninth bit was low |
| busy | output | 1 | START, STOP or byte in progress, or a START/STOP pending |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| sda_i | input | 1 | Wired-AND SDA level |

## Verification
The bench uses the default widths (DW = 8, PW = 8). It switches the prescaler between 3 and 1 at run time, which gives 16- and 8-cycle bit periods. These short periods let complete write, read, NACK and wrong-address transactions fit inside a short run. They also allow the SCL spacing to be measured against both settings.

A behavioural target on the wired-AND lines records address and data bytes and the master's acknowledge. A reference of bus ownership is checked on every clock. The direction-mismatch and busy cases are judged by counting SCL edges at the pins.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [2:0] {
    ENG_IDLE  = 3'd0,
    ENG_START = 3'd1,
    ENG_HOLD  = 3'd2,
    ENG_BIT   = 3'd3,
    ENG_STOP  = 3'd4
  } eng_st_e;

  localparam int unsigned PHASES_PER_BIT = 4;
endpackage

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
  parameter int unsigned PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [PW-1:0] presc,
  output logic          tick
);
  logic [PW-1:0] cnt_q, cnt_d;
  logic          at_end;

  assign at_end = (cnt_q == presc);
  assign tick   = at_end && !clr;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    if (clr || at_end) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/i2cm_bit_engine.sv
module i2cm_bit_engine
  import i2cm_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          start_req,
  input  logic          stop_req,
  input  logic          byte_go,
  input  logic          go_tx,
  input  logic [DW-1:0] tx_byte,
  input  logic          ack_drive,
  input  logic          sda_i,
  output logic          st_idle,
  output logic          st_hold,
  output logic          byte_end,
  output logic [DW-1:0] rx_byte,
  output logic          ack_sample,
  output logic          scl_oe,
  output logic          sda_oe
);
  localparam int unsigned BW = $clog2(DW + 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(DW);
  localparam logic [1:0]    PH_LAST  = 2'(PHASES_PER_BIT - 1);

  eng_st_e       st_q, st_d;
  logic [1:0]    ph_q, ph_d;
  logic [BW-1:0] bit_q, bit_d;
  logic [DW-1:0] sh_q, sh_d;
  logic          dir_tx_q, dir_tx_d;
  logic          ackdrv_q, ackdrv_d;
  logic          ack_q, ack_d;
  logic          data_bit;

  assign st_idle    = (st_q == ENG_IDLE);
  assign st_hold    = (st_q == ENG_HOLD);
  assign rx_byte    = sh_q;
  assign ack_sample = ack_q;
  assign data_bit   = (bit_q != LAST_BIT);
  assign byte_end   = (st_q == ENG_BIT) && tick && (ph_q == PH_LAST) && !data_bit;

  // line drive decode from registered state
  always_comb begin
    scl_oe = 1'b0;
    sda_oe = 1'b0;
    unique case (st_q)
      ENG_IDLE: ;
      ENG_START: begin
        sda_oe = (ph_q != 2'd0);
        scl_oe = (ph_q == 2'd2);
      end
      ENG_HOLD: begin
        sda_oe = 1'b1;
        scl_oe = 1'b1;
      end
      ENG_BIT: begin
        scl_oe = (ph_q == 2'd0) || (ph_q == PH_LAST);
        if (data_bit) sda_oe = dir_tx_q && !sh_q[DW-1];
        else          sda_oe = !dir_tx_q && ackdrv_q;
      end
      ENG_STOP: begin
        scl_oe = (ph_q == 2'd0);
        sda_oe = (ph_q != 2'd2);
      end
      default: ;
    endcase
  end

  // next state
  always_comb begin
    st_d     = st_q;
    ph_d     = ph_q;
    bit_d    = bit_q;
    sh_d     = sh_q;
    dir_tx_d = dir_tx_q;
    ackdrv_d = ackdrv_q;
    ack_d    = ack_q;
    unique case (st_q)
      ENG_IDLE: begin
        if (start_req) begin
          st_d = ENG_START;
          ph_d = 2'd0;
        end
      end
      ENG_START: begin
        if (tick) begin
          if (ph_q == 2'd2) st_d = ENG_HOLD;
          else              ph_d = ph_q + 2'd1;
        end
      end
      ENG_HOLD: begin
        if (stop_req) begin
          st_d = ENG_STOP;
          ph_d = 2'd0;
        end else if (byte_go) begin
          st_d     = ENG_BIT;
          ph_d     = 2'd0;
          bit_d    = '0;
          sh_d     = tx_byte;
          dir_tx_d = go_tx;
          ackdrv_d = ack_drive;
        end
      end
      ENG_BIT: begin
        if (tick) begin
          if (ph_q == 2'd2) begin
            if (data_bit) sh_d = {sh_q[DW-2:0], sda_i};
            else          ack_d = sda_i;
          end
          if (ph_q == PH_LAST) begin
            ph_d = 2'd0;
            if (data_bit) bit_d = bit_q + 1'b1;
            else          st_d  = ENG_HOLD;
          end else begin
            ph_d = ph_q + 2'd1;
          end
        end
      end
      ENG_STOP: begin
        if (tick) begin
          if (ph_q == 2'd2) st_d = ENG_IDLE;
          else              ph_d = ph_q + 2'd1;
        end
      end
      default: st_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ENG_IDLE;
      ph_q     <= '0;
      bit_q    <= '0;
      sh_q     <= '0;
      dir_tx_q <= 1'b0;
      ackdrv_q <= 1'b0;
      ack_q    <= 1'b1;
    end else begin
      st_q     <= st_d;
      ph_q     <= ph_d;
      bit_q    <= bit_d;
      sh_q     <= sh_d;
      dir_tx_q <= dir_tx_d;
      ackdrv_q <= ackdrv_d;
      ack_q    <= ack_d;
    end
  end

  // R3
  sda_steady_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ENG_BIT && $past(st_q == ENG_BIT) && !scl_oe && $past(!scl_oe)) |-> $stable(sda_oe));

  // R9
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ENG_IDLE && $past(st_q == ENG_STOP)) |-> (!scl_oe && !sda_oe));
endmodule

// File: rtl/i2cm_reg_master.sv
module i2cm_reg_master #(
  parameter int unsigned DW = 8,
  parameter int unsigned PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] presc,
  input  logic          ctrl_we,
  input  logic          ctrl_master,
  input  logic          ctrl_tx,
  input  logic          ctrl_nack,
  input  logic          data_we,
  input  logic [DW-1:0] data_wdata,
  input  logic          data_re,
  output logic [DW-1:0] data_rdata,
  output logic          xfer_done,
  output logic          ack_seen,
  output logic          busy,
  output logic          scl_oe,
  output logic          sda_oe,
  input  logic          sda_i
);
  logic ms_q, ms_d, tx_q, tx_d, nack_q, nack_d;
  logic start_pend_q, start_pend_d, stop_pend_q, stop_pend_d;
  logic done_q, done_d, ackr_q, ackr_d, dir_q, dir_d;
  logic [DW-1:0] rx_q, rx_d;

  logic tick, st_idle, st_hold, byte_end, ack_sample;
  logic start_req, stop_req, go_wr, go_rd, byte_go, can_go;
  logic ms_rise, ms_fall;
  logic [DW-1:0] eng_rx;

  assign ms_rise   = ctrl_we && ctrl_master && !ms_q;
  assign ms_fall   = ctrl_we && !ctrl_master && ms_q;
  assign start_req = start_pend_q && st_idle;
  assign stop_req  = stop_pend_q && st_hold;
  assign can_go    = ms_q && st_hold && !stop_pend_q;
  assign go_wr     = data_we && tx_q && can_go;
  assign go_rd     = data_re && !tx_q && can_go;
  assign byte_go   = go_wr || go_rd;

  assign data_rdata = rx_q;
  assign xfer_done  = done_q;
  assign ack_seen   = ackr_q;
  assign busy       = start_pend_q || stop_pend_q || !(st_idle || st_hold);

  i2cm_tick #(.PW(PW)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (st_idle || st_hold),
    .presc (presc),
    .tick  (tick)
  );

  i2cm_bit_engine #(.DW(DW)) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .start_req  (start_req),
    .stop_req   (stop_req),
    .byte_go    (byte_go),
    .go_tx      (go_wr),
    .tx_byte    (data_wdata),
    .ack_drive  (!nack_q),
    .sda_i      (sda_i),
    .st_idle    (st_idle),
    .st_hold    (st_hold),
    .byte_end   (byte_end),
    .rx_byte    (eng_rx),
    .ack_sample (ack_sample),
    .scl_oe     (scl_oe),
    .sda_oe     (sda_oe)
  );

  always_comb begin
    ms_d   = ctrl_we ? ctrl_master : ms_q;
    tx_d   = ctrl_we ? ctrl_tx     : tx_q;
    nack_d = ctrl_we ? ctrl_nack   : nack_q;

    start_pend_d = start_pend_q;
    if (start_req) start_pend_d = 1'b0;
    if (ms_rise)   start_pend_d = 1'b1;
    if (ms_fall)   start_pend_d = 1'b0;

    stop_pend_d = stop_pend_q;
    if (stop_req) stop_pend_d = 1'b0;
    if (ms_fall)  stop_pend_d = 1'b1;

    done_d = done_q;
    ackr_d = ackr_q;
    dir_d  = dir_q;
    rx_d   = rx_q;
    if (byte_go) begin
      done_d = 1'b0;
      dir_d  = go_wr;
    end
    if (byte_end) begin
      done_d = 1'b1;
      ackr_d = !ack_sample;
      if (!dir_q) rx_d = eng_rx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms_q         <= 1'b0;
      tx_q         <= 1'b0;
      nack_q       <= 1'b0;
      start_pend_q <= 1'b0;
      stop_pend_q  <= 1'b0;
      done_q       <= 1'b0;
      ackr_q       <= 1'b0;
      dir_q        <= 1'b0;
      rx_q         <= '0;
    end else begin
      ms_q         <= ms_d;
      tx_q         <= tx_d;
      nack_q       <= nack_d;
      start_pend_q <= start_pend_d;
      stop_pend_q  <= stop_pend_d;
      done_q       <= done_d;
      ackr_q       <= ackr_d;
      dir_q        <= dir_d;
      rx_q         <= rx_d;
    end
  end

  // R5
  done_after_ninth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_end |=> (xfer_done && (ack_seen == !$past(ack_sample))));

  // R7
  rd_in_tx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_re && !data_we && ms_q && tx_q && st_hold && !stop_pend_q && !ctrl_we) |=> st_hold);

  // R8
  wr_in_rx_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && !tx_q && !byte_end) |=> $stable(data_rdata));
endmodule

// File: tb/tb_i2cm_reg_master.sv
module tb_i2cm_reg_master;
  localparam int DW = 8;
  localparam int PW = 8;
  localparam logic [6:0] TGT = 7'h52;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PW-1:0] presc = 8'd3;
  logic ctrl_we = 1'b0, ctrl_master = 1'b0, ctrl_tx = 1'b0, ctrl_nack = 1'b0;
  logic data_we = 1'b0, data_re = 1'b0;
  logic [DW-1:0] data_wdata = '0;
  logic [DW-1:0] data_rdata;
  logic xfer_done, ack_seen, busy, scl_oe, sda_oe;
  logic slv_drv = 1'b0;
  logic sda_w;

  always #2.5 clk = ~clk;

  assign sda_w = !(sda_oe || slv_drv);

  i2cm_reg_master #(.DW(DW), .PW(PW)) dut (
    .clk(clk), .rst_n(rst_n), .presc(presc),
    .ctrl_we(ctrl_we), .ctrl_master(ctrl_master), .ctrl_tx(ctrl_tx), .ctrl_nack(ctrl_nack),
    .data_we(data_we), .data_wdata(data_wdata), .data_re(data_re), .data_rdata(data_rdata),
    .xfer_done(xfer_done), .ack_seen(ack_seen), .busy(busy),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_i(sda_w)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reference model state
  bit ref_ms = 0;
  bit ref_owned = 0;
  int n_start = 0, n_stop = 0, n_rise = 0, last_rise = 0, last_period = 0;
  bit prev_scl = 1, prev_sda = 1;
  bit s_act = 0, s_addr = 0, s_rd = 0, s_match = 0, s_mack = 1;
  int s_cnt = 0, rd_idx = 0, n_wr = 0;
  logic [7:0] s_sh = 0, s_byte = 0, last_addr = 0, last_wr = 0;
  logic [7:0] rd_data [2];
  initial begin rd_data[0] = 8'h96; rd_data[1] = 8'h5B; end

  always @(negedge clk) begin
    bit scl_now, sda_now;
    cyc++;
    scl_now = !scl_oe;
    sda_now = sda_w;
    if (rst_n && !ref_owned && !(scl_now && sda_now) && !(scl_now && prev_scl && prev_sda && !sda_now))
      chk(0, "R2", "lines low while bus not owned", {scl_now, sda_now}, 3);
    if (prev_scl && scl_now && prev_sda && !sda_now) begin
      n_start++;
      chk(ref_ms && !ref_owned, "R2", "START allowed", ref_ms, 1);
      ref_owned = 1;
      s_act = 1; s_cnt = 0; s_addr = 1; s_rd = 0; s_match = 0; slv_drv = 0;
    end else if (prev_scl && scl_now && !prev_sda && sda_now) begin
      n_stop++;
      chk(!ref_ms && ref_owned, "R9", "STOP allowed", ref_ms, 0);
      ref_owned = 0;
      s_act = 0; slv_drv = 0;
    end else if (!prev_scl && scl_now) begin
      n_rise++;
      last_period = cyc - last_rise;
      last_rise = cyc;
      if (s_act) begin
        s_cnt++;
        if (s_cnt <= 8 && (s_addr || !s_rd)) s_sh = {s_sh[6:0], sda_now};
        if (s_cnt == 9 && s_rd && !s_addr) s_mack = sda_now;
      end
    end else if (prev_scl && !scl_now && s_act) begin
      if (s_cnt == 8 && (s_addr || !s_rd)) begin
        if (s_addr) begin
          s_match = (s_sh[7:1] == TGT);
          s_rd = s_sh[0];
          last_addr = s_sh;
        end else begin
          last_wr = s_sh;
          n_wr++;
        end
        slv_drv = s_match;
      end else if (s_cnt == 8) begin
        slv_drv = 0;
      end else if (s_cnt == 9) begin
        s_cnt = 0;
        slv_drv = 0;
        if (s_addr) begin
          s_addr = 0;
          if (s_rd && s_match) begin
            s_byte = rd_data[rd_idx];
            slv_drv = !s_byte[7];
          end
        end else if (s_rd && s_match && !s_mack) begin
          rd_idx = (rd_idx + 1) % 2;
          s_byte = rd_data[rd_idx];
          slv_drv = !s_byte[7];
        end
      end else if (s_cnt >= 1 && s_cnt <= 7 && s_rd && !s_addr && s_match) begin
        slv_drv = !s_byte[7 - s_cnt];
      end
    end
    prev_scl = scl_now;
    prev_sda = sda_now;
  end

  task automatic set_ctrl(input bit ms, input bit tx, input bit nk);
    @(negedge clk);
    ctrl_we = 1; ctrl_master = ms; ctrl_tx = tx; ctrl_nack = nk;
    ref_ms = ms;
    @(negedge clk);
    ctrl_we = 0;
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk);
    data_we = 1; data_wdata = b;
    @(negedge clk);
    data_we = 0;
  endtask

  task automatic rd();
    @(negedge clk);
    data_re = 1;
    @(negedge clk);
    data_re = 0;
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "R11", "watchdog expired", cyc, 0);
    summary();
    $finish;
  end

  initial begin
    int r0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(data_rdata == 8'h00, "R1", "rdata", data_rdata, 0);
    chk(!xfer_done, "R1", "done", xfer_done, 0);
    chk(!scl_oe && !sda_oe, "R1", "lines", {scl_oe, sda_oe}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R2 START then SCL held low
    set_ctrl(1, 1, 0);
    wait_idle();
    chk(n_start == 1, "R2", "start count", n_start, 1);
    chk(scl_oe, "R2", "scl held low", scl_oe, 1);

    // R4 address write phase
    wr({TGT, 1'b0});
    wait_idle();
    chk(last_addr == {TGT, 1'b0}, "R4", "address seen", last_addr, {TGT, 1'b0});
    chk(xfer_done, "R5", "done after address", xfer_done, 1);
    chk(ack_seen, "R5", "address ACK", ack_seen, 1);

    // R3 data byte MSB first, R10 period with presc=3
    wr(8'h3C);
    wait_idle();
    chk(last_wr == 8'h3C && n_wr == 1, "R3", "byte at target", last_wr, 8'h3C);
    chk(ack_seen, "R5", "data ACK", ack_seen, 1);
    chk(last_period == 16, "R10", "scl period p3", last_period, 16);

    // R7 read in transmit mode starts nothing
    r0 = n_rise;
    rd();
    repeat (60) @(negedge clk);
    chk(n_rise == r0, "R7", "no scl edges", n_rise - r0, 0);
    chk(xfer_done && !busy, "R7", "done kept", xfer_done, 1);

    // R9 STOP
    set_ctrl(0, 1, 0);
    wait_idle();
    chk(n_stop == 1, "R9", "stop count", n_stop, 1);
    chk(!scl_oe && !sda_oe, "R9", "released", {scl_oe, sda_oe}, 0);

    // R5 wrong address gives NACK
    set_ctrl(1, 1, 0);
    wait_idle();
    wr(8'h20);
    wait_idle();
    chk(!ack_seen && xfer_done, "R5", "NACK on wrong address", ack_seen, 0);
    set_ctrl(0, 1, 0);
    wait_idle();

    // R6 receive with presc=1
    presc = 8'd1;
    set_ctrl(1, 1, 0);
    wait_idle();
    wr({TGT, 1'b1});
    wait_idle();
    chk(ack_seen, "R4", "read address ACK", ack_seen, 1);
    set_ctrl(1, 0, 0);
    rd();
    wait_idle();
    chk(data_rdata == 8'h96, "R6", "first rx byte", data_rdata, 8'h96);
    chk(s_mack == 0, "R6", "master ACK", s_mack, 0);
    chk(last_period == 8, "R10", "scl period p1", last_period, 8);

    // R8 write in receive mode
    r0 = n_rise;
    wr(8'h11);
    repeat (60) @(negedge clk);
    chk(n_rise == r0, "R8", "no scl edges", n_rise - r0, 0);
    chk(data_rdata == 8'h96, "R8", "rdata kept", data_rdata, 8'h96);

    // R6 NACK on last byte, R11 second read while busy ignored
    set_ctrl(1, 0, 1);
    r0 = n_rise;
    rd();
    rd();
    wait_idle();
    chk(n_rise - r0 == 9, "R11", "one byte only", n_rise - r0, 9);
    chk(data_rdata == 8'h5B, "R6", "second rx byte", data_rdata, 8'h5B);
    chk(s_mack == 1, "R6", "master NACK", s_mack, 1);

    set_ctrl(0, 0, 0);
    wait_idle();
    chk(n_stop == 3, "R9", "stop count end", n_stop, 3);
    chk(!scl_oe && !sda_oe, "R9", "released end", {scl_oe, sda_oe}, 0);

    summary();
    $finish;
  end
endmodule